// File: doc/BRIEF.md
# Transmit Queue with Threshold Interrupt and DMA Request

This block holds the characters a host has queued for serial transmission: 64 entries, each one byte wide. The host writes bytes into the holding register, and the serializer removes them through a show-ahead pop port. The block also tells the host when to refill. It drives a holding-empty interrupt with service and re-arm rules, and it drives a separate DMA ready request that follows its own set and clear conditions.

A 2-bit select sets the trigger level as a number of free slots. When the threshold is enabled, the interrupt is raised once enough slots are free. When the threshold is disabled, the interrupt is raised only when the queue runs dry. The interrupt is serviced by a write to the holding register or by a read of the identification register. These two services are not equivalent: a read alone leaves the queue unable to raise an empty interrupt until the host writes again. After a threshold interrupt, the host must write two characters before the threshold interrupt can fire again. A clear strobe flushes the queue and sets the interrupt pending.

Top module: `txq_thre_ctrl`

## Requirements
- R1: A synchronous active-high reset leaves the queue empty (`srl_valid`=0) with `thre_irq`=1, `dma_req`=1 and `ovf_flag`=0.
- R2: Bytes leave on `srl_data` in the order they were written. `srl_data` always shows the oldest byte while `srl_valid`=1. A push and a pop in the same cycle leave the occupancy unchanged.
- R3: A write while the queue holds 64 bytes, with no pop in that cycle, is dropped and sets `ovf_flag`. The flag stays set until reset or `txq_clr`.
- R4: `lvl_sel` picks the trigger level in free slots: 00→8, 01→16, 10→32, 11→56. With `lvl_en`=1 and the threshold armed, `thre_irq` rises on the clock edge after the free-slot count first equals or exceeds the level.
- R5: Once raised, `thre_irq` stays high until a write to the holding register (`hw_wr`) or an identification read (`iid_rd`) clears it on the next edge.
- R6: After a threshold interrupt, the threshold cannot raise `thre_irq` again until two writes have been made. A single write followed by more draining raises nothing until the queue is empty.
- R7: After an interrupt that was serviced only by `iid_rd`, draining the queue to empty raises no interrupt while no write occurs.
- R8: After at least one write following an interrupt, the queue reaching empty raises `thre_irq` on the following edge.
- R9: With `lvl_en`=0, `thre_irq` is raised only by the queue becoming empty, whatever the occupancy otherwise.
- R10: `dma_req` rises when the free-slot count exceeds the selected level. It falls only on the edge after the queue is full, and it stays high while the queue refills below full.
- R11: `txq_clr` empties the queue, clears `ovf_flag`, sets `thre_irq`, and sets `dma_req`.
- R12: A host write in a cycle where a fire condition holds takes precedence: `thre_irq` is low after that edge, and the interrupt fires on a later idle cycle if it is still armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hw_wr | input | 1 | Host write strobe to the holding register |
| hw_data | input | 8 | Byte written by the host |
| iid_rd | input | 1 | Host read of the interrupt identification register |
| txq_clr | input | 1 | Queue flush strobe |
| lvl_en | input | 1 | Threshold enable |
| lvl_sel | input | 2 | Trigger level select (00=8, 01=16, 10=32, 11=56 free slots) |
| srl_pop | input | 1 | Serializer takes the oldest byte |
| srl_valid | output | 1 | Queue holds at least one byte |
| srl_data | output | 8 | Oldest byte in the queue |
| thre_irq | output | 1 | Holding-empty interrupt |
| dma_req | output | 1 | DMA transmit-ready request |
| ovf_flag | output | 1 | Sticky dropped-write flag |

## Verification
Two pairs of events can land in the same cycle. The first is a host write arriving in the very cycle a fire condition holds. The bench provokes this with a back-to-back write burst whose second write arms the threshold while the free count is already above the level. It then requires the interrupt to be low after the burst and high one idle cycle later. The second is a push that coincides with a pop. The bench judges this by the byte order that follows and by the number of pops needed to empty the queue.

// File: rtl/txq_pkg.sv
package txq_pkg;

  // Trigger level in free slots for a 2-bit select, scaled to the queue depth.
  function automatic int unsigned level_slots(input logic [1:0] sel,
                                              input int unsigned depth);
    int unsigned r;
    case (sel)
      2'b00:   r = depth / 8;
      2'b01:   r = depth / 4;
      2'b10:   r = depth / 2;
      default: r = depth - depth / 8;
    endcase
    return r;
  endfunction

  // Next occupancy given the accepted push and pop of a cycle.
  function automatic int unsigned next_occ(input int unsigned occ,
                                           input logic push,
                                           input logic pop);
    int unsigned r;
    r = occ;
    if (push && !pop) r = occ + 1;
    if (pop && !push) r = occ - 1;
    return r;
  endfunction

endpackage

// File: rtl/txq_store.sv
module txq_store #(
  parameter int DEPTH = 64,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          wr,
  input  logic [DW-1:0] wdata,
  input  logic          pop,
  output logic [DW-1:0] rdata,
  output logic [CW-1:0] occ,
  output logic          push_ok,
  output logic          pop_ok,
  output logic          at_full,
  output logic          at_empty,
  output logic          ovf
);
  localparam logic [CW-1:0] FULL_C = CW'(DEPTH);

  logic [DW-1:0] slot [DEPTH];
  logic [AW-1:0] wr_ptr;
  logic [AW-1:0] rd_ptr;

  assign at_full  = (occ == FULL_C);
  assign at_empty = (occ == '0);
  assign pop_ok   = pop && !at_empty && !clr;
  assign push_ok  = wr && !clr && (!at_full || pop_ok);
  assign rdata    = slot[rd_ptr];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (push_ok && (wr_ptr == AW'(g))) slot[g] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      occ    <= '0;
      ovf    <= 1'b0;
    end else begin
      if (push_ok) wr_ptr <= wr_ptr + AW'(1);
      if (pop_ok)  rd_ptr <= rd_ptr + AW'(1);
      occ <= CW'(txq_pkg::next_occ(int'(occ), push_ok, pop_ok));
      if (wr && !push_ok) ovf <= 1'b1;
    end
  end

endmodule

// File: rtl/txq_irq.sv
module txq_irq #(
  parameter int CW = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          host_wr,
  input  logic          iid_rd,
  input  logic          lvl_en,
  input  logic [CW-1:0] level,
  input  logic [CW-1:0] free_cnt,
  input  logic          at_empty,
  output logic          fire_thr,
  output logic          fire_empty,
  output logic          irq
);
  logic       thr_armed;
  logic       empty_armed;
  logic [1:0] wr_seen;

  logic thr_cond;
  logic empty_cond;

  assign thr_cond   = lvl_en && thr_armed && (free_cnt >= level);
  assign empty_cond = empty_armed && at_empty;
  assign fire_thr   = thr_cond && !host_wr && !clr;
  assign fire_empty = empty_cond && !host_wr && !clr;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      irq         <= 1'b1;
      thr_armed   <= 1'b0;
      empty_armed <= 1'b0;
      wr_seen     <= 2'd0;
    end else if (host_wr) begin
      irq         <= 1'b0;
      empty_armed <= 1'b1;
      thr_armed   <= (wr_seen != 2'd0);
      if (wr_seen != 2'd2) wr_seen <= wr_seen + 2'd1;
    end else if (fire_thr || fire_empty) begin
      irq         <= 1'b1;
      thr_armed   <= 1'b0;
      empty_armed <= 1'b0;
      wr_seen     <= 2'd0;
    end else if (iid_rd) begin
      irq <= 1'b0;
    end
  end

endmodule

// File: rtl/txq_dma.sv
module txq_dma #(
  parameter int DEPTH = 64,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic [CW-1:0] occ,
  input  logic [CW-1:0] free_cnt,
  input  logic [CW-1:0] level,
  output logic          req
);
  localparam logic [CW-1:0] FULL_C = CW'(DEPTH);

  always_ff @(posedge clk) begin
    if (rst || clr)               req <= 1'b1;
    else if (occ == FULL_C)       req <= 1'b0;
    else if (free_cnt > level)    req <= 1'b1;
  end

endmodule

// File: rtl/txq_thre_ctrl.sv
module txq_thre_ctrl #(
  parameter int DEPTH = 64,
  parameter int DW    = 8,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          hw_wr,
  input  logic [DW-1:0] hw_data,
  input  logic          iid_rd,
  input  logic          txq_clr,
  input  logic          lvl_en,
  input  logic [1:0]    lvl_sel,
  input  logic          srl_pop,
  output logic          srl_valid,
  output logic [DW-1:0] srl_data,
  output logic          thre_irq,
  output logic          dma_req,
  output logic          ovf_flag
);
  localparam logic [CW-1:0] FULL_C = CW'(DEPTH);

  logic [CW-1:0] occ;
  logic [CW-1:0] free_cnt;
  logic [CW-1:0] level;
  logic          push_ok;
  logic          pop_ok;
  logic          at_full;
  logic          at_empty;
  logic          fire_thr;
  logic          fire_empty;
  logic          fire_any;

  assign free_cnt  = FULL_C - occ;
  assign level     = CW'(txq_pkg::level_slots(lvl_sel, DEPTH));
  assign fire_any  = fire_thr || fire_empty;
  assign srl_valid = !at_empty;

  txq_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
    .clk      (clk),
    .rst      (rst),
    .clr      (txq_clr),
    .wr       (hw_wr),
    .wdata    (hw_data),
    .pop      (srl_pop),
    .rdata    (srl_data),
    .occ      (occ),
    .push_ok  (push_ok),
    .pop_ok   (pop_ok),
    .at_full  (at_full),
    .at_empty (at_empty),
    .ovf      (ovf_flag)
  );

  txq_irq #(.CW(CW)) u_irq (
    .clk        (clk),
    .rst        (rst),
    .clr        (txq_clr),
    .host_wr    (hw_wr),
    .iid_rd     (iid_rd),
    .lvl_en     (lvl_en),
    .level      (level),
    .free_cnt   (free_cnt),
    .at_empty   (at_empty),
    .fire_thr   (fire_thr),
    .fire_empty (fire_empty),
    .irq        (thre_irq)
  );

  txq_dma #(.DEPTH(DEPTH)) u_dma (
    .clk      (clk),
    .rst      (rst),
    .clr      (txq_clr),
    .occ      (occ),
    .free_cnt (free_cnt),
    .level    (level),
    .req      (dma_req)
  );

endmodule

// File: rtl/txq_thre_ctrl_chk.sv
module txq_thre_ctrl_chk #(
  parameter int DEPTH = 64,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst,
  input logic          hw_wr,
  input logic          iid_rd,
  input logic          txq_clr,
  input logic          thre_irq,
  input logic          dma_req,
  input logic          ovf_flag,
  input logic [CW-1:0] occ,
  input logic          push_ok,
  input logic          pop_ok,
  input logic          fire_any,
  input logic          at_full
);

  p_pushpop_r2: assert property (@(posedge clk) disable iff (rst)
    push_ok && pop_ok && !txq_clr |=> $stable(occ));

  p_full_drop_r3: assert property (@(posedge clk) disable iff (rst)
    at_full && hw_wr && !pop_ok && !txq_clr |=> ovf_flag && $stable(occ));

  p_ovf_sticky_r3: assert property (@(posedge clk) disable iff (rst)
    ovf_flag && !txq_clr |=> ovf_flag);

  p_irq_hold_r5: assert property (@(posedge clk) disable iff (rst)
    thre_irq && !hw_wr && !iid_rd |=> thre_irq);

  p_iid_clear_r5: assert property (@(posedge clk) disable iff (rst)
    iid_rd && !hw_wr && !txq_clr && !fire_any |=> !thre_irq);

  p_write_wins_r12: assert property (@(posedge clk) disable iff (rst)
    hw_wr && !txq_clr |=> !thre_irq);

  p_dma_full_r10: assert property (@(posedge clk) disable iff (rst)
    at_full && !txq_clr |=> !dma_req);

  p_dma_fall_r10: assert property (@(posedge clk) disable iff (rst)
    $fell(dma_req) |-> $past(at_full));

  p_clr_state_r11: assert property (@(posedge clk) disable iff (rst)
    txq_clr |=> thre_irq && !ovf_flag && (occ == '0) && dma_req);

endmodule

bind txq_thre_ctrl txq_thre_ctrl_chk #(.DEPTH(DEPTH)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .hw_wr    (hw_wr),
  .iid_rd   (iid_rd),
  .txq_clr  (txq_clr),
  .thre_irq (thre_irq),
  .dma_req  (dma_req),
  .ovf_flag (ovf_flag),
  .occ      (occ),
  .push_ok  (push_ok),
  .pop_ok   (pop_ok),
  .fire_any (fire_any),
  .at_full  (at_full)
);

// File: tb/txq_thre_ctrl_test.sv
module txq_thre_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 64;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       hw_wr = 1'b0;
  logic [7:0] hw_data = '0;
  logic       iid_rd = 1'b0;
  logic       txq_clr = 1'b0;
  logic       lvl_en = 1'b1;
  logic [1:0] lvl_sel = 2'b00;
  logic       srl_pop = 1'b0;
  logic       srl_valid;
  logic [7:0] srl_data;
  logic       thre_irq;
  logic       dma_req;
  logic       ovf_flag;

  int errors = 0;
  int checks = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  txq_thre_ctrl #(.DEPTH(DEPTH), .DW(8)) uut (
    .clk       (clk),
    .rst       (rst),
    .hw_wr     (hw_wr),
    .hw_data   (hw_data),
    .iid_rd    (iid_rd),
    .txq_clr   (txq_clr),
    .lvl_en    (lvl_en),
    .lvl_sel   (lvl_sel),
    .srl_pop   (srl_pop),
    .srl_valid (srl_valid),
    .srl_data  (srl_data),
    .thre_irq  (thre_irq),
    .dma_req   (dma_req),
    .ovf_flag  (ovf_flag)
  );

  // Trigger level restated from R4: 8, 16, 32, 56 free slots.
  function automatic int lvl_of(input logic [1:0] s);
    int t[4] = '{8, 16, 32, 56};
    return t[s];
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic flush();
    txq_clr = 1'b1; tick(); txq_clr = 1'b0;
  endtask

  task automatic burst(input int n, input int base);
    hw_wr = 1'b1;
    for (int i = 0; i < n; i++) begin
      hw_data = 8'(base + i);
      tick();
    end
    hw_wr = 1'b0;
  endtask

  task automatic popn(input int n);
    srl_pop = 1'b1;
    repeat (n) tick();
    srl_pop = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 valid", srl_valid, 0);
    chk("R1 irq", thre_irq, 1);
    chk("R1 dma", dma_req, 1);
    chk("R1 ovf", ovf_flag, 0);
  endtask

  task automatic t_order();
    lvl_en = 1'b1; lvl_sel = 2'b00; flush();
    burst(3, 8'h11);
    chk("R2 head", srl_data, 8'h11);
    popn(1);
    chk("R2 second", srl_data, 8'h12);
    hw_wr = 1'b1; hw_data = 8'h14; srl_pop = 1'b1; tick();
    hw_wr = 1'b0; srl_pop = 1'b0;
    chk("R2 after push+pop", srl_data, 8'h13);
    popn(1);
    chk("R2 pushed byte", srl_data, 8'h14);
    chk("R2 still one left", srl_valid, 1);
    popn(1);
    chk("R2 empty after pops", srl_valid, 0);
  endtask

  task automatic t_overflow();
    flush();
    burst(DEPTH, 0);
    chk("R3 no ovf at full", ovf_flag, 0);
    burst(1, 8'hEE);
    chk("R3 ovf set", ovf_flag, 1);
    tick(); tick();
    chk("R3 ovf sticky", ovf_flag, 1);
    for (int i = 0; i < DEPTH; i++) begin
      if (srl_data != 8'(i)) chk("R3 data kept", srl_data, i);
      popn(1);
    end
    chk("R3 dropped byte absent", srl_valid, 0);
    flush();
    chk("R11 ovf cleared", ovf_flag, 0);
    chk("R11 irq set", thre_irq, 1);
    chk("R11 dma set", dma_req, 1);
    chk("R11 emptied", srl_valid, 0);
  endtask

  task automatic t_level(input logic [1:0] s);
    int lv;
    lv = lvl_of(s);
    lvl_en = 1'b1; lvl_sel = s; flush();
    burst(DEPTH - lv + 4, 0);
    popn(3); tick();
    chk($sformatf("R4 sel%0d below level", s), thre_irq, 0);
    popn(1); tick();
    chk($sformatf("R4 sel%0d at level", s), thre_irq, 1);
  endtask

  task automatic t_service();
    lvl_en = 1'b1; lvl_sel = 2'b00; flush();
    burst(60, 0);
    popn(4); tick();
    chk("R4 fire at 8 free", thre_irq, 1);
    tick(); tick(); tick();
    chk("R5 held", thre_irq, 1);
    burst(1, 8'hA0);
    chk("R5 write clears", thre_irq, 0);
    popn(1); tick();
    chk("R6 one write no refire", thre_irq, 0);
    popn(6); tick();
    chk("R6 still quiet", thre_irq, 0);
    burst(1, 8'hA1);
    chk("R12 write cycle low", thre_irq, 0);
    tick();
    chk("R6 rearmed after two writes", thre_irq, 1);
    iid_rd = 1'b1; tick(); iid_rd = 1'b0;
    chk("R5 iid read clears", thre_irq, 0);
    popn(51); tick(); tick();
    chk("R7 drained empty", srl_valid, 0);
    chk("R7 no empty irq after read", thre_irq, 0);
    burst(1, 8'hB0);
    popn(1);
    chk("R8 not yet", thre_irq, 0);
    tick();
    chk("R8 empty irq after write", thre_irq, 1);
  endtask

  task automatic t_disabled();
    lvl_en = 1'b0; lvl_sel = 2'b00; flush();
    burst(10, 0);
    popn(8); tick(); tick();
    chk("R9 no threshold irq", thre_irq, 0);
    popn(2); tick();
    chk("R9 empty irq", thre_irq, 1);
    lvl_en = 1'b1;
  endtask

  task automatic t_collide();
    lvl_en = 1'b1; lvl_sel = 2'b00; flush();
    burst(3, 0);
    chk("R12 write beats fire", thre_irq, 0);
    tick();
    chk("R12 fires on idle", thre_irq, 1);
  endtask

  task automatic t_dma();
    lvl_en = 1'b1; lvl_sel = 2'b00; flush();
    chk("R10 dma after clear", dma_req, 1);
    burst(DEPTH, 0);
    chk("R10 dma before full seen", dma_req, 1);
    tick();
    chk("R10 dma drops at full", dma_req, 0);
    popn(8); tick();
    chk("R10 dma off at equal", dma_req, 0);
    popn(1); tick();
    chk("R10 dma on when exceeding", dma_req, 1);
    burst(1, 0); tick();
    chk("R10 dma holds while refilling", dma_req, 1);
  endtask

  initial begin
    repeat (3) tick();
    rst = 1'b0;
    tick();
    t_reset();
    t_order();
    t_overflow();
    for (int s = 0; s < 4; s++) t_level(2'(s));
    t_service();
    t_disabled();
    t_collide();
    t_dma();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 50000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule